// File: doc/BRIEF.md
# Chained Message Frame Transmitter

This block turns a message that a host has written into a local word queue into a stream of 10-bit link words for a daisy chain of front-end nodes. The host writes 16-bit words one at a time, then pulses a send command. The block then drains exactly the words that were in the queue at that moment. Each word is split into two bytes, with the more significant byte first. Every byte goes out with a two-bit control tag. A final word carries a CRC-8 of all bytes sent before it.

By convention the message holds one address byte, eight header bytes and an odd number of payload bytes. The host always supplies a whole number of 16-bit words. The block does not inspect these groups: it tags the first byte as the start and appends the checksum word tagged as the end. A link lock input pauses the stream. While lock is low the output carries a fixed sync pattern instead of data, and transmission picks up where it stopped once lock returns.

The sequencer has four states. IDLE waits for an accepted send and then goes to HIGH. HIGH emits the upper byte and goes to LOW. LOW emits the lower byte, pops the queue, and goes back to HIGH, or to CHECK after the last word. CHECK emits the checksum word and returns to IDLE. In HIGH, LOW and CHECK the state is held for every cycle in which lock is low.

Top module: `chain_frame_tx`

## Requirements
- R1: Each valid link word carries a control tag in bits [9:8] and a byte in bits [7:0]. The tag is 2'b10 on the first byte of a message, 2'b00 on every other data byte and 2'b01 on the checksum word. A valid word never carries 2'b11.
- R2: Each 16-bit queue word is sent as two link words: bits [15:8] first, then bits [7:0], with words in the order they were written.
- R3: A message sends exactly the words held in the queue at the cycle the send is accepted, 2 link words each plus one checksum word. The queue is empty afterwards if nothing was written during transmission.
- R4: The checksum byte is CRC-8 with polynomial x^8+x^2+x+1 (0x07), initial value 0x00, fed most significant bit first over every byte of the message in transmission order.
- R5: A send pulse is ignored while the queue is empty or while a message is in progress. Busy stays low in the first case, and no extra message is produced in either case.
- R6: The queue holds FIFO_DEPTH (default 1024) words. The full flag is high when it holds FIFO_DEPTH words, and writes while full are discarded.
- R7: The empty flag is high exactly when the queue holds no words, and empty and full are never high together.
- R8: msg_sent is low after reset, goes high in the same cycle the checksum word appears, stays high, and is cleared in the cycle after a send is accepted.
- R9: In the cycle after link_lock is sampled low, link_valid is 0 and link_word is the sync pattern 10'h3C5. No byte is skipped or repeated across a lock loss.
- R10: After reset, and whenever no data word is output, link_valid is 0 and link_word is 10'h3C5. After reset busy is 0, fifo_empty is 1 and fifo_full is 0.
- R11: Words written while a message is in transmission are kept in order and form the next message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe for the word queue |
| wr_data | input | 16 | Host word, upper byte sent first |
| send | input | 1 | Send command pulse |
| link_lock | input | 1 | Downstream receiver lock; low pauses data |
| fifo_empty | output | 1 | Queue holds no words |
| fifo_full | output | 1 | Queue holds FIFO_DEPTH words |
| busy | output | 1 | A message is in progress |
| msg_sent | output | 1 | Last message completed |
| link_word | output | 10 | Control tag and byte to the serializer |
| link_valid | output | 1 | link_word carries message data |

## Verification
The assertions check on every cycle that no data leaves in the cycle after lock is sampled low, that tags are legal, and that start and end tags alternate. They also check that msg_sent rises only together with a checksum word, and that the queue flags are never both high. Only the bench's scenarios can show that the byte order, message length and checksum value are correct. The same holds for the queue size limit with a discarded extra write, for ignored send pulses, and for words written mid-transmission reaching the next message. All of these are compared against a model of the queue under randomly toggling lock.

// File: rtl/chain_frame_tx_pkg.sv
package chain_frame_tx_pkg;
    localparam int          BYTE_W    = 8;
    localparam int          HWORD_W   = 2 * BYTE_W;
    localparam int          LINK_W    = BYTE_W + 2;
    localparam logic [1:0]  TAG_START = 2'b10;
    localparam logic [1:0]  TAG_MID   = 2'b00;
    localparam logic [1:0]  TAG_END   = 2'b01;
    localparam logic [LINK_W-1:0] SYNC_WORD = 10'h3C5;
    localparam logic [BYTE_W-1:0] CRC_POLY  = 8'h07;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HIGH,
        ST_LOW,
        ST_CHECK
    } tx_state_e;

    // one byte into the running checksum, most significant bit first
    function automatic logic [BYTE_W-1:0] crc_step(input logic [BYTE_W-1:0] acc,
                                                   input logic [BYTE_W-1:0] din);
        logic [BYTE_W-1:0] r;
        logic              fb;
        r = acc;
        for (int i = BYTE_W - 1; i >= 0; i--) begin
            fb = r[BYTE_W-1] ^ din[i];
            r  = {r[BYTE_W-2:0], 1'b0};
            if (fb) r = r ^ CRC_POLY;
        end
        return r;
    endfunction
endpackage

// File: rtl/frame_word_queue.sv
module frame_word_queue #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CW-1:0]    level,
    output logic             empty,
    output logic             full
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic             do_push, do_pop;

    assign full    = (level == CW'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
            if (do_push && !do_pop)      level <= level + CW'(1);
            else if (do_pop && !do_push) level <= level - CW'(1);
        end
    end
endmodule

// File: rtl/frame_sequencer.sv
module frame_sequencer
    import chain_frame_tx_pkg::*;
#(
    parameter int CW = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               send,
    input  logic               link_lock,
    input  logic [CW-1:0]      q_level,
    input  logic [HWORD_W-1:0] q_head,
    output logic               q_pop,
    output logic [LINK_W-1:0]  link_word,
    output logic               link_valid,
    output logic               busy,
    output logic               msg_sent
);
    tx_state_e         state_q, state_d;
    logic [CW-1:0]     left_q;
    logic              first_q;
    logic [BYTE_W-1:0] crc_q;
    logic              accept;

    assign accept = (state_q == ST_IDLE) && send && (q_level != '0);
    assign q_pop  = (state_q == ST_LOW) && link_lock;
    assign busy   = (state_q != ST_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept)    state_d = ST_HIGH;
            ST_HIGH:  if (link_lock) state_d = ST_LOW;
            ST_LOW:   if (link_lock) state_d = (left_q == CW'(1)) ? ST_CHECK : ST_HIGH;
            ST_CHECK: if (link_lock) state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_word  <= SYNC_WORD;
            link_valid <= 1'b0;
            left_q     <= '0;
            first_q    <= 1'b0;
            crc_q      <= '0;
            msg_sent   <= 1'b0;
        end else begin
            link_word  <= SYNC_WORD;
            link_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        left_q   <= q_level;
                        first_q  <= 1'b1;
                        crc_q    <= '0;
                        msg_sent <= 1'b0;
                    end
                end
                ST_HIGH: begin
                    if (link_lock) begin
                        link_word  <= {first_q ? TAG_START : TAG_MID, q_head[HWORD_W-1:BYTE_W]};
                        link_valid <= 1'b1;
                        crc_q      <= crc_step(crc_q, q_head[HWORD_W-1:BYTE_W]);
                        first_q    <= 1'b0;
                    end
                end
                ST_LOW: begin
                    if (link_lock) begin
                        link_word  <= {TAG_MID, q_head[BYTE_W-1:0]};
                        link_valid <= 1'b1;
                        crc_q      <= crc_step(crc_q, q_head[BYTE_W-1:0]);
                        left_q     <= left_q - CW'(1);
                    end
                end
                ST_CHECK: begin
                    if (link_lock) begin
                        link_word  <= {TAG_END, crc_q};
                        link_valid <= 1'b1;
                        msg_sent   <= 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/chain_frame_tx.sv
module chain_frame_tx
    import chain_frame_tx_pkg::*;
#(
    parameter int FIFO_DEPTH = 1024,
    localparam int CW        = $clog2(FIFO_DEPTH) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [15:0]        wr_data,
    input  logic               send,
    input  logic               link_lock,
    output logic               fifo_empty,
    output logic               fifo_full,
    output logic               busy,
    output logic               msg_sent,
    output logic [9:0]         link_word,
    output logic               link_valid
);
    logic [HWORD_W-1:0] q_head;
    logic [CW-1:0]      q_level;
    logic               q_pop;

    frame_word_queue #(
        .WIDTH (HWORD_W),
        .DEPTH (FIFO_DEPTH)
    ) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_en),
        .push_data (wr_data),
        .pop       (q_pop),
        .head      (q_head),
        .level     (q_level),
        .empty     (fifo_empty),
        .full      (fifo_full)
    );

    frame_sequencer #(
        .CW (CW)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .send       (send),
        .link_lock  (link_lock),
        .q_level    (q_level),
        .q_head     (q_head),
        .q_pop      (q_pop),
        .link_word  (link_word),
        .link_valid (link_valid),
        .busy       (busy),
        .msg_sent   (msg_sent)
    );
endmodule

// File: rtl/chain_frame_tx_chk.sv
module chain_frame_tx_chk
    import chain_frame_tx_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       link_lock,
    input logic       link_valid,
    input logic [9:0] link_word,
    input logic       msg_sent,
    input logic       fifo_empty,
    input logic       fifo_full
);
    logic in_msg;
    logic is_start, is_end;

    assign is_start = link_valid && (link_word[9:8] == TAG_START);
    assign is_end   = link_valid && (link_word[9:8] == TAG_END);

    always_ff @(posedge clk) begin
        if (!rst_n)        in_msg <= 1'b0;
        else if (is_start) in_msg <= 1'b1;
        else if (is_end)   in_msg <= 1'b0;
    end

    p_no_data_unlocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !link_lock |=> !link_valid);

    p_tag_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        link_valid |-> link_word[9:8] != 2'b11);

    p_start_outside_r1: assert property (@(posedge clk) disable iff (!rst_n)
        is_start |-> !in_msg);

    p_end_inside_r4: assert property (@(posedge clk) disable iff (!rst_n)
        is_end |-> in_msg);

    p_sent_with_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_sent) |-> is_end);

    p_idle_sync_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !link_valid |-> link_word == SYNC_WORD);

    p_flags_apart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_empty && fifo_full));
endmodule

bind chain_frame_tx chain_frame_tx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .link_lock  (link_lock),
    .link_valid (link_valid),
    .link_word  (link_word),
    .msg_sent   (msg_sent),
    .fifo_empty (fifo_empty),
    .fifo_full  (fifo_full)
);

// File: tb/sim_chain_frame_tx.sv
module sim_chain_frame_tx;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 1024;
    localparam logic [9:0] SYNC = 10'h3C5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        send = 1'b0;
    logic        link_lock = 1'b1;
    logic        fifo_empty, fifo_full, busy, msg_sent, link_valid;
    logic [9:0]  link_word;

    int total = 0;
    int bad   = 0;
    bit lock_rand = 1'b0;
    bit lock_prev = 1'b1;
    logic [15:0] model_q[$];
    logic [9:0]  lw_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    chain_frame_tx #(.FIFO_DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .send(send),
        .link_lock(link_lock), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
        .busy(busy), .msg_sent(msg_sent), .link_word(link_word), .link_valid(link_valid)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // reference checksum: xor byte in, then eight shifts
    function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] b);
        logic [7:0] x;
        x = c ^ b;
        repeat (8) x = x[7] ? ((x << 1) ^ 8'h07) : (x << 1);
        return x;
    endfunction

    // monitor and lock driver on the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (link_valid) lw_q.push_back(link_word);
            if (!lock_prev) // R9
                check(!link_valid && link_word == SYNC, "R9 sync while unlocked",
                      {link_valid, link_word}, {1'b0, SYNC});
        end
        link_lock = lock_rand ? (($urandom % 4) != 0) : 1'b1;
        lock_prev = link_lock;
    end

    task automatic write_word(input logic [15:0] w);
        wr_en   = 1'b1;
        wr_data = w;
        if (model_q.size() < DEPTH) model_q.push_back(w);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_send(input int n_extra, input bit resend);
        logic [15:0] snap[$];
        logic [9:0]  exp_q[$];
        logic [7:0]  crc;
        int          mism;
        snap = model_q;
        model_q.delete();
        lw_q.delete();
        send = 1'b1;
        @(negedge clk);
        send = 1'b0;
        check(busy && !msg_sent, "R8 send clears sent", {busy, msg_sent}, 2'b10);
        if (resend) begin
            send = 1'b1;
            @(negedge clk);
            send = 1'b0;
        end
        for (int i = 0; i < n_extra; i++) write_word(16'($urandom));
        while (busy) @(negedge clk);
        @(negedge clk);
        crc = 8'h00;
        foreach (snap[i]) begin
            exp_q.push_back({(i == 0) ? 2'b10 : 2'b00, snap[i][15:8]});
            exp_q.push_back({2'b00, snap[i][7:0]});
            crc = ref_crc(crc, snap[i][15:8]);
            crc = ref_crc(crc, snap[i][7:0]);
        end
        exp_q.push_back({2'b01, crc});
        check(lw_q.size() == exp_q.size(), "R3 message length", lw_q.size(), exp_q.size());
        if (lw_q.size() == exp_q.size()) begin
            mism = -1;
            for (int i = 0; i < exp_q.size() - 1; i++)
                if (mism < 0 && lw_q[i] != exp_q[i]) mism = i;
            check(mism < 0, "R1 R2 tags and byte order",
                  (mism < 0) ? 0 : lw_q[mism], (mism < 0) ? 0 : exp_q[mism]);
            check(lw_q[exp_q.size()-1] == exp_q[exp_q.size()-1], "R4 checksum word",
                  lw_q[exp_q.size()-1], exp_q[exp_q.size()-1]);
        end
        check(msg_sent, "R8 sent after end", msg_sent, 1);
        check(fifo_empty == (model_q.size() == 0), "R7 R11 empty after message",
              fifo_empty, model_q.size() == 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(!link_valid && link_word == SYNC, "R10 reset output", {link_valid, link_word}, {1'b0, SYNC});
        check(!busy && fifo_empty && !fifo_full && !msg_sent, "R10 reset flags",
              {busy, fifo_empty, fifo_full, msg_sent}, 4'b0100);

        // R5 send with empty queue
        send = 1'b1;
        @(negedge clk);
        send = 1'b0;
        @(negedge clk);
        check(!busy && lw_q.size() == 0 && !msg_sent, "R5 empty send ignored",
              {busy, msg_sent, 30'(lw_q.size())}, 0);

        // minimal shaped message: address, 8 header bytes, one payload byte
        for (int i = 0; i < 5; i++) write_word(16'h1100 * 16'(i + 1) + 16'h0033);
        check(!fifo_empty, "R7 not empty after writes", fifo_empty, 0);
        run_send(0, 1'b0);
        check(!link_valid && link_word == SYNC, "R10 idle output", {link_valid, link_word}, {1'b0, SYNC});

        // single-word message boundary
        write_word(16'hA55A);
        run_send(0, 1'b0);

        // R5 send while busy, R11 writes during transmission
        for (int i = 0; i < 6; i++) write_word(16'($urandom));
        run_send(3, 1'b1);
        check(!fifo_empty, "R11 mid-message writes kept", fifo_empty, 0);
        run_send(0, 1'b0);

        // random lengths under random lock loss (R9 resume)
        lock_rand = 1'b1;
        for (int m = 0; m < 6; m++) begin
            n = 5 + int'($urandom % 36);
            for (int i = 0; i < n; i++) write_word(16'($urandom));
            run_send((m == 2) ? 2 : 0, m[0]);
        end
        lock_rand = 1'b0;
        if (model_q.size() != 0) run_send(0, 1'b0);

        // R6 full queue and discarded write
        for (int i = 0; i < DEPTH; i++) write_word(16'($urandom));
        check(fifo_full && !fifo_empty, "R6 full at depth", {fifo_full, fifo_empty}, 2'b10);
        write_word(16'hDEAD);
        check(fifo_full, "R6 still full after extra write", fifo_full, 1);
        run_send(0, 1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule